// File: doc/BRIEF.md
# GPIO Bank with Pin Interrupt Detection

This block is a sixteen-pin general-purpose I/O bank on a plain 16-bit register bus. Each pin has its own bit in a set of configuration registers: output enable, output value, alternate-function select, interrupt mask, trigger kind, edge polarity, level polarity and wake mask. Pin inputs pass through a two-flop synchroniser. The synchronised levels can be read back. They also feed a per-pin detector that catches either an edge or an active level.

Detected events collect in a sticky pending register. Software clears it by writing zeros to the bits it wants to drop. The bank drives two registered summary lines. One is an interrupt, raised by any pending bit whose mask bit is 0. The other is a wake request, raised by any pending bit whose wake-mask bit is 0. Because edge polarity can be rewritten at run time without causing a false event, software can emulate a both-edges trigger by flipping the polarity after each event.

The bus has no stream traffic and no back-pressure. A write takes effect at the clock edge where `reg_en` and `reg_wr` are both high. Read data is combinational from the addressed register while `reg_en` is high and `reg_wr` is low.

Top module: `gpio_irq_bank`

## Requirements
- R1: The register offsets are: 0 output enable, 1 output value, 2 alternate select, 3 live input (read-only), 4 interrupt mask, 5 trigger kind, 6 edge polarity, 7 level polarity, 8 pending, 9 wake mask. Reads return the stored value. A read of any other offset returns 0. Writes to offset 3 or to unlisted offsets change nothing.
- R2: Bit i of every register belongs to pin i. `pin_oe` equals the output-enable register (1 = output, 0 = input), and `pin_out` equals the output-value register. After reset both registers are 0.
- R3: `alt_sel` equals the alternate-select register, which resets to 0.
- R4: Offset 3 returns the pin levels after a two-flop synchroniser. A change on `pin_in` set up before clock edge E is visible in a read after edge E+1.
- R5: With trigger-kind bit 1 (edge), an edge-polarity bit of 1 latches a rising edge and 0 latches a falling edge. The pending bit is set at the third clock edge after the pin changes.
- R6: With trigger-kind bit 0 (level), a level-polarity bit of 1 means active-high and 0 means active-low. The pending bit is set in every cycle the active level is present, and it stays set after the level goes away. After reset, trigger kind and level polarity are 0.
- R7: A write to offset 8 clears every pending bit written as 0 and keeps every bit written as 1, so writing 0 clears the whole bank. An event in the same cycle as the write wins and leaves its bit set.
- R8: `irq_out` is high one cycle after any pending bit is set while its mask bit is 0. The mask resets to all ones, which keeps `irq_out` low.
- R9: Rewriting an edge-polarity bit while the pin is steady sets no pending bit. The pin's next transition in the new direction is latched.
- R10: `wake_out` is high one cycle after any pending bit is set while its wake-mask bit is 0 (1 blocks the pin). The wake mask resets to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output values |
| pin_oe | output | 16 | Output enables |
| alt_sel | output | 16 | Alternate-function select |
| irq_out | output | 1 | Summary interrupt |
| wake_out | output | 1 | Summary wake request |

## Verification
The bench goes after four corner cases.

- **Polarity flip on a steady high pin.** A design that detects by level instead of by transition would latch a false event at the moment of the flip.
- **Clearing while a level is still active.** A design that gives the clear priority would drop a live event.
- **Partial clears.** A design that treats any write as "clear all" would lose the bits that were written as 1.
- **Mask and wake-mask boundaries.** A design with the polarity of either mask inverted would raise `irq_out` or `wake_out` straight out of reset.

Reads of the live status just after a pin change confirm the two-cycle synchroniser latency. A block that reads the raw pins would return the new value early.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int REG_ADDR_W = 4;

  typedef enum logic [REG_ADDR_W-1:0] {
    OFS_OE    = 4'd0,
    OFS_DOUT  = 4'd1,
    OFS_ALT   = 4'd2,
    OFS_LIVE  = 4'd3,
    OFS_IMASK = 4'd4,
    OFS_KIND  = 4'd5,
    OFS_EPOL  = 4'd6,
    OFS_LPOL  = 4'd7,
    OFS_PEND  = 4'd8,
    OFS_WMASK = 4'd9
  } reg_ofs_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= din;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[STAGES-1];

  // R4
  sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout == $past(stg[STAGES-2]));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_bank_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_en,
  input  logic                  reg_wr,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]          reg_wdata,
  output logic [W-1:0]          reg_rdata,
  input  logic [W-1:0]          live,
  input  logic [W-1:0]          pend,
  output logic [W-1:0]          oe_q,
  output logic [W-1:0]          dout_q,
  output logic [W-1:0]          alt_q,
  output logic [W-1:0]          imask_q,
  output logic [W-1:0]          kind_q,
  output logic [W-1:0]          epol_q,
  output logic [W-1:0]          lpol_q,
  output logic [W-1:0]          wmask_q,
  output logic                  pend_wr,
  output logic [W-1:0]          pend_wdata
);
  logic     wr_hit;
  reg_ofs_e ofs;

  assign wr_hit     = reg_en & reg_wr;
  assign ofs        = reg_ofs_e'(reg_addr);
  assign pend_wr    = wr_hit && (ofs == OFS_PEND);
  assign pend_wdata = reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q    <= '0;
      dout_q  <= '0;
      alt_q   <= '0;
      imask_q <= '1;
      kind_q  <= '0;
      epol_q  <= '0;
      lpol_q  <= '0;
      wmask_q <= '1;
    end else if (wr_hit) begin
      case (ofs)
        OFS_OE:    oe_q    <= reg_wdata;
        OFS_DOUT:  dout_q  <= reg_wdata;
        OFS_ALT:   alt_q   <= reg_wdata;
        OFS_IMASK: imask_q <= reg_wdata;
        OFS_KIND:  kind_q  <= reg_wdata;
        OFS_EPOL:  epol_q  <= reg_wdata;
        OFS_LPOL:  lpol_q  <= reg_wdata;
        OFS_WMASK: wmask_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_en && !reg_wr) begin
      case (ofs)
        OFS_OE:    reg_rdata = oe_q;
        OFS_DOUT:  reg_rdata = dout_q;
        OFS_ALT:   reg_rdata = alt_q;
        OFS_LIVE:  reg_rdata = live;
        OFS_IMASK: reg_rdata = imask_q;
        OFS_KIND:  reg_rdata = kind_q;
        OFS_EPOL:  reg_rdata = epol_q;
        OFS_LPOL:  reg_rdata = lpol_q;
        OFS_PEND:  reg_rdata = pend;
        OFS_WMASK: reg_rdata = wmask_q;
        default:   reg_rdata = '0;
      endcase
    end
  end

  // R2
  oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && ofs == OFS_OE) |=> (oe_q == $past(reg_wdata)));
endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] kind,
  input  logic [W-1:0] epol,
  input  logic [W-1:0] lpol,
  input  logic         pend_wr,
  input  logic [W-1:0] pend_wdata,
  output logic [W-1:0] pend_q
);
  logic [W-1:0] prev_q;
  logic [W-1:0] hit;
  logic [W-1:0] keep;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall;
    assign rise   = lvl[i] & ~prev_q[i];
    assign fall   = ~lvl[i] & prev_q[i];
    assign hit[i] = kind[i] ? (epol[i] ? rise : fall) : (lvl[i] ~^ lpol[i]);
  end

  assign keep = pend_wr ? pend_wdata : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lvl;
      pend_q <= (pend_q & keep) | hit;
    end
  end

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_wr |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R7
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_wr && pend_wdata == '0 && hit == '0) |=> (pend_q == '0));

  // R9
  steady_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == prev_q && kind == '1 && !pend_wr) |=> (pend_q == $past(pend_q)));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_en,
  input  logic                  reg_wr,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [NPINS-1:0]      reg_wdata,
  output logic [NPINS-1:0]      reg_rdata,
  input  logic [NPINS-1:0]      pin_in,
  output logic [NPINS-1:0]      pin_out,
  output logic [NPINS-1:0]      pin_oe,
  output logic [NPINS-1:0]      alt_sel,
  output logic                  irq_out,
  output logic                  wake_out
);
  logic [NPINS-1:0] live;
  logic [NPINS-1:0] pend;
  logic [NPINS-1:0] imask, kind, epol, lpol, wmask;
  logic             pend_wr;
  logic [NPINS-1:0] pend_wdata;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(live)
  );

  gpio_regfile #(.W(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .live(live), .pend(pend),
    .oe_q(pin_oe), .dout_q(pin_out), .alt_q(alt_sel),
    .imask_q(imask), .kind_q(kind), .epol_q(epol), .lpol_q(lpol),
    .wmask_q(wmask), .pend_wr(pend_wr), .pend_wdata(pend_wdata)
  );

  gpio_event_detect #(.W(NPINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .lvl(live),
    .kind(kind), .epol(epol), .lpol(lpol),
    .pend_wr(pend_wr), .pend_wdata(pend_wdata), .pend_q(pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_out  <= 1'b0;
      wake_out <= 1'b0;
    end else begin
      irq_out  <= |(pend & ~imask);
      wake_out <= |(pend & ~wmask);
    end
  end

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imask == '1) |=> !irq_out);

  // R10
  wake_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |=> !wake_out);
endmodule

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_en = 1'b0, reg_wr = 1'b0;
  logic [3:0]   reg_addr = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out, pin_oe, alt_sel;
  logic         irq_out, wake_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_irq_bank u_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .alt_sel(alt_sel),
    .irq_out(irq_out), .wake_out(wake_out)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [W-1:0] m_oe, m_dout, m_alt, m_imask, m_kind, m_epol, m_lpol, m_wmask, m_pend;
  logic         m_irq, m_wake;
  logic [W-1:0] hq[$];

  function automatic logic [W-1:0] model_read(logic [3:0] a);
    case (a)
      4'd0: return m_oe;
      4'd1: return m_dout;
      4'd2: return m_alt;
      4'd3: return hq[1];
      4'd4: return m_imask;
      4'd5: return m_kind;
      4'd6: return m_epol;
      4'd7: return m_lpol;
      4'd8: return m_pend;
      4'd9: return m_wmask;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_oe = '0; m_dout = '0; m_alt = '0; m_kind = '0; m_epol = '0; m_lpol = '0;
      m_imask = '1; m_wmask = '1; m_pend = '0; m_irq = 0; m_wake = 0;
      hq = '{'0, '0, '0};
    end else begin
      logic [W-1:0] now_lvl, old_lvl, ev, keep;
      now_lvl = hq[1];
      old_lvl = hq[2];
      for (int i = 0; i < W; i++) begin
        if (m_kind[i])
          ev[i] = m_epol[i] ? (now_lvl[i] && !old_lvl[i]) : (!now_lvl[i] && old_lvl[i]);
        else
          ev[i] = (now_lvl[i] == m_lpol[i]);
      end
      m_irq  = (m_pend & ~m_imask) != 0;
      m_wake = (m_pend & ~m_wmask) != 0;
      keep = (reg_en && reg_wr && reg_addr == 4'd8) ? reg_wdata : '1;
      m_pend = (m_pend & keep) | ev;
      if (reg_en && reg_wr) begin
        case (reg_addr)
          4'd0: m_oe = reg_wdata;
          4'd1: m_dout = reg_wdata;
          4'd2: m_alt = reg_wdata;
          4'd4: m_imask = reg_wdata;
          4'd5: m_kind = reg_wdata;
          4'd6: m_epol = reg_wdata;
          4'd7: m_lpol = reg_wdata;
          4'd9: m_wmask = reg_wdata;
          default: ;
        endcase
      end
      hq.push_front(pin_in);
      void'(hq.pop_back());
    end
    #2;
    if (rst_n && !done) begin
      check("R2 pin_oe", pin_oe, m_oe);
      check("R2 pin_out", pin_out, m_dout);
      check("R3 alt_sel", alt_sel, m_alt);
      check("R8 irq_out", irq_out, m_irq);
      check("R10 wake_out", wake_out, m_wake);
      if (reg_en && !reg_wr) check("R1 read data", reg_rdata, model_read(reg_addr));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [W-1:0] d);
    @(negedge clk); #1;
    reg_en = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_en = 0; reg_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, logic [W-1:0] exp, string tag);
    @(negedge clk); #1;
    reg_en = 1; reg_wr = 0; reg_addr = a;
    #2;
    check(tag, reg_rdata, exp);
    @(negedge clk); #1;
    reg_en = 0;
  endtask

  task automatic pins(logic [W-1:0] v);
    @(negedge clk); #1;
    pin_in = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    @(negedge clk); #1 rst_n = 1;
    // reset state
    rd(4'd4, 16'hFFFF, "R8 mask resets to ones");
    rd(4'd9, 16'hFFFF, "R10 wake mask resets to ones");
    rd(4'd0, 16'h0000, "R2 output enable resets to zero");
    check("R8 irq low after reset", irq_out, 1'b0);
    rd(4'd8, 16'hFFFF, "R6 level-low default latches low pins");
    // configure: all edge, pins 0-7 rising, pins 0-3 unmasked
    wr(4'd5, 16'hFFFF);
    wr(4'd8, 16'h0000);
    wr(4'd6, 16'h00FF);
    wr(4'd4, 16'hFFF0);
    rd(4'd8, 16'h0000, "R7 write zero clears all");
    // output side and decode
    wr(4'd0, 16'hA5A5);
    wr(4'd1, 16'h1234);
    wr(4'd2, 16'h0F0F);
    check("R2 pin_oe", pin_oe, 16'hA5A5);
    check("R2 pin_out", pin_out, 16'h1234);
    check("R3 alt_sel", alt_sel, 16'h0F0F);
    wr(4'hF, 16'hFFFF);
    wr(4'd3, 16'hFFFF);
    rd(4'hF, 16'h0000, "R1 unlisted offset reads zero");
    rd(4'd3, 16'h0000, "R1 live register not writable");
    rd(4'd2, 16'h0F0F, "R1 alt readback");
    // rising edge on pin 0
    pins(16'h0001); idle(5);
    rd(4'd8, 16'h0001, "R5 rising edge latched");
    check("R8 irq on unmasked pending", irq_out, 1'b1);
    // falling edge on pin 8
    pins(16'h0101); idle(5);
    rd(4'd8, 16'h0001, "R5 rise ignored on falling pin");
    pins(16'h0001); idle(5);
    rd(4'd8, 16'h0101, "R5 falling edge latched");
    wr(4'd8, 16'h0000); idle(2);
    rd(4'd8, 16'h0000, "R7 clear all");
    check("R8 irq drops after clear", irq_out, 1'b0);
    // partial clear
    pins(16'h0007); idle(5);
    rd(4'd8, 16'h0006, "R5 two rising edges");
    wr(4'd8, 16'h0004);
    rd(4'd8, 16'h0004, "R7 ones kept on partial clear");
    wr(4'd8, 16'h0000);
    // polarity flip
    wr(4'd6, 16'h00FE); idle(5);
    rd(4'd8, 16'h0000, "R9 flip gives no spurious event");
    pins(16'h0006); idle(5);
    rd(4'd8, 16'h0001, "R9 opposite edge latched");
    wr(4'd8, 16'h0000);
    wr(4'd6, 16'h00FF); idle(5);
    rd(4'd8, 16'h0000, "R9 flip back no spurious event");
    pins(16'h0007); idle(5);
    rd(4'd8, 16'h0001, "R9 rising re-armed");
    wr(4'd8, 16'h0000);
    // level mode on pin 4
    wr(4'd7, 16'h0010);
    wr(4'd5, 16'hFFEF); idle(3);
    rd(4'd8, 16'h0000, "R6 inactive level no event");
    pins(16'h0017); idle(3);
    wr(4'd8, 16'h0000);
    rd(4'd8, 16'h0010, "R7 active level wins over clear");
    pins(16'h0007); idle(5);
    rd(4'd8, 16'h0010, "R6 pending sticky after level drops");
    wr(4'd8, 16'h0000); idle(2);
    rd(4'd8, 16'h0000, "R6 clear after level gone");
    wr(4'd7, 16'h0000); idle(2);
    rd(4'd8, 16'h0010, "R6 active-low level latched");
    // wake
    wr(4'd9, 16'hFFEF); idle(2);
    check("R10 wake raised", wake_out, 1'b1);
    wr(4'd9, 16'hFFFF); idle(2);
    check("R10 wake blocked", wake_out, 1'b0);
    // mask boundary
    wr(4'd4, 16'hFFE0); idle(2);
    check("R8 irq unmasked pin 4", irq_out, 1'b1);
    wr(4'd4, 16'hFFFF); idle(2);
    check("R8 irq fully masked", irq_out, 1'b0);
    // synchroniser latency
    pins(16'hBEEF);
    #0 rd(4'd3, 16'h0007, "R4 live read not yet updated");
    idle(3);
    rd(4'd3, 16'hBEEF, "R4 live read after sync");
    idle(4);
    finish_run();
  end
endmodule